// File: doc/BRIEF.md
# SPI panel power-up sequencer

This block brings a small TFT display panel from a powered-down state to a configured, running one. It also takes the panel back down. A prepare request raises a supply-enable request to the power domain and waits for its acknowledge. It then holds the panel reset line active for a fixed time, releases it, and waits for a second settling interval. After that it streams a fixed list of register writes to the panel over a write-only SPI link. It ends with a one-cycle done pulse, or with an error pulse if the supply acknowledge is lost partway through the writes.

Separate wake and sleep requests each write one standby-control register. After a wake, a ready pulse reports that the picture is valid. With a backlight fitted, this pulse waits a long settling time; without one, it follows the write straight away. An unprepare request puts the panel back into reset and then withdraws the supply request. All requests are single-cycle control pulses. They are accepted only while the block is idle; `busy` is high otherwise.

The register link carries no data stream from outside, so the block has no back-pressure at its edge. Its shifter takes one 16-bit word at a time from the sequencer through a valid/ready handshake inside the block. While a frame is on the wire, the sequencer holds the next word.

Top module: `panel_seq_top`

## Requirements
- R1: After reset, `panel_rst` is 1, `supply_req` is 0, `spi_csn` is 1, `spi_sck` is 0 and `busy` is 0.
- R2: On prepare, `supply_req` rises. Once `supply_ack` is seen, `panel_rst` stays 1 for at least 50 µs and then falls. At least a further 50 µs pass before the first frame starts.
- R3: Each register write is one frame of 16 bits. `spi_csn` is low for the whole frame and high between frames. The 8-bit address goes first, then the 8-bit data, each most significant bit first. `spi_sck` idles low. `spi_mosi` changes only on a falling edge, so it is valid on every rising edge.
- R4: Prepare sends exactly 35 frames, in a fixed order. The first two write address 0x05 with 0x1E and then 0x5C. Two banks of ten writes cover addresses 0x30 to 0x39 and 0x40 to 0x49. No address exceeds 0x5A. `prep_done` pulses once, after the last frame has ended.
- R5: Wake sends one frame, address 0x2B with data 0x01. With `backlight_present` at 0, `pic_ready` pulses within a few cycles after that frame. With it at 1, `pic_ready` waits at least 120 ms after the frame.
- R6: Sleep sends one frame, address 0x2B with data 0x00.
- R7: Unprepare sets `panel_rst` to 1 one cycle before `supply_req` falls.
- R8: If `supply_ack` is low at a frame boundary during the init writes, the block sends no more frames. It drops `supply_req`, pulses `prep_err` and gives no `prep_done`.
- R9: A request that arrives while `busy` is 1 is ignored and produces no frame.
- R10: When several requests arrive in the same idle cycle, only one is served. The order of priority is unprepare, then sleep, then wake, then prepare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prep_req | input | 1 | Prepare request pulse |
| unprep_req | input | 1 | Unprepare request pulse |
| wake_req | input | 1 | Leave-standby request pulse |
| sleep_req | input | 1 | Enter-standby request pulse |
| backlight_present | input | 1 | A backlight is fitted; lengthens the wake wait |
| supply_ack | input | 1 | Supply-enable acknowledge |
| supply_req | output | 1 | Supply-enable request |
| panel_rst | output | 1 | Panel reset, 1 = held in reset |
| spi_csn | output | 1 | SPI chip select, active low |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI serial data |
| busy | output | 1 | A sequence is running; requests are ignored |
| prep_done | output | 1 | One-cycle pulse: init writes complete |
| prep_err | output | 1 | One-cycle pulse: init aborted |
| pic_ready | output | 1 | One-cycle pulse: picture valid after wake |

## Verification
Two pairs of requests are raised in the same clock cycle while the block is idle. Wake and sleep together must yield only the standby-enter frame. Unprepare and prepare together must leave the supply request low and the panel in reset, with no frame at all. A wake request is also raised in the middle of the init stream, the case where a new request overlaps a running sequence. Every clock, the reference model checks that the bus stays quiet whenever it expects no frame. Each frame that ends is compared against its queue of expected words.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

  localparam int         INIT_LEN  = 35;
  localparam int         FRAME_W   = 16;
  localparam logic [7:0] STBY_ADDR = 8'h2B;
  localparam logic [7:0] MAX_ADDR  = 8'h5A;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
  } reg_wr_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PWR, ST_RSTHOLD, ST_SETTLE, ST_INIT,
    ST_ONE, ST_DRAIN, ST_BLWAIT, ST_UNPREP
  } seq_st_e;

  typedef enum logic [1:0] {OP_PREP, OP_WAKE, OP_SLEEP} seq_op_e;

endpackage

// File: rtl/panel_init_rom.sv
module panel_init_rom
  import panel_seq_pkg::*;
#(
  parameter int IW = 6
) (
  input  logic [IW-1:0] idx,
  output reg_wr_t       wr
);

  // Ordered panel configuration; replay order matters for the first two.
  always_comb begin
    case (idx)
      IW'(0):  wr = '{8'h05, 8'h1E};
      IW'(1):  wr = '{8'h05, 8'h5C};
      IW'(2):  wr = '{8'h02, 8'h14};
      IW'(3):  wr = '{8'h03, 8'h40};
      IW'(4):  wr = '{8'h04, 8'h07};
      IW'(5):  wr = '{8'h06, 8'h12};
      IW'(6):  wr = '{8'h07, 8'hD2};
      IW'(7):  wr = '{8'h0C, 8'h06};
      IW'(8):  wr = '{8'h0D, 8'h40};
      IW'(9):  wr = '{8'h0E, 8'h40};
      IW'(10): wr = '{8'h0F, 8'h40};
      IW'(11): wr = '{8'h10, 8'h40};
      IW'(12): wr = '{8'h11, 8'h40};
      IW'(13): wr = '{8'h2F, 8'h40};
      IW'(14): wr = '{8'h5A, 8'h02};
      IW'(15): wr = '{8'h30, 8'h07};
      IW'(16): wr = '{8'h31, 8'h57};
      IW'(17): wr = '{8'h32, 8'h53};
      IW'(18): wr = '{8'h33, 8'h77};
      IW'(19): wr = '{8'h34, 8'hB8};
      IW'(20): wr = '{8'h35, 8'hBD};
      IW'(21): wr = '{8'h36, 8'hB8};
      IW'(22): wr = '{8'h37, 8'hE7};
      IW'(23): wr = '{8'h38, 8'h04};
      IW'(24): wr = '{8'h39, 8'hFF};
      IW'(25): wr = '{8'h40, 8'h0B};
      IW'(26): wr = '{8'h41, 8'hB8};
      IW'(27): wr = '{8'h42, 8'hAB};
      IW'(28): wr = '{8'h43, 8'hB9};
      IW'(29): wr = '{8'h44, 8'h6A};
      IW'(30): wr = '{8'h45, 8'h56};
      IW'(31): wr = '{8'h46, 8'h61};
      IW'(32): wr = '{8'h47, 8'h08};
      IW'(33): wr = '{8'h48, 8'h0F};
      IW'(34): wr = '{8'h49, 8'h0F};
      default: wr = '{8'h00, 8'h00};
    endcase
  end

endmodule

// File: rtl/panel_delay.sv
module panel_delay #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] load,
  output logic         expired
);

  logic [W-1:0] cnt;
  logic         run;

  // Loads load-1 and counts to zero: expired is seen exactly load cycles after start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= load - W'(1);
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - W'(1);
    end
  end

  assign expired = run && (cnt == '0);

endmodule

// File: rtl/panel_spi_tx.sv
module panel_spi_tx #(
  parameter int FRAME_W = 16,
  parameter int HALF    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic [FRAME_W-1:0] in_data,
  output logic               in_rdy,
  output logic               csn,
  output logic               sck,
  output logic               mosi
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW = $clog2(FRAME_W);
  localparam logic [CW-1:0] HALF_END = CW'(HALF - 1);
  localparam logic [BW-1:0] BIT_END  = BW'(FRAME_W - 1);

  typedef enum logic [1:0] {T_IDLE, T_LO, T_HI, T_GAP} tx_st_e;

  tx_st_e             st;
  logic [CW-1:0]      cnt;
  logic [BW-1:0]      bitn;
  logic [FRAME_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= T_IDLE;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
      csn  <= 1'b1;
      sck  <= 1'b0;
    end else begin
      case (st)
        T_IDLE: if (in_vld) begin
          sh   <= in_data;
          csn  <= 1'b0;
          cnt  <= '0;
          bitn <= '0;
          st   <= T_LO;
        end
        T_LO: begin
          if (cnt == HALF_END) begin
            cnt <= '0;
            sck <= 1'b1;
            st  <= T_HI;
          end else cnt <= cnt + CW'(1);
        end
        T_HI: begin
          if (cnt == HALF_END) begin
            cnt <= '0;
            sck <= 1'b0;
            if (bitn == BIT_END) begin
              csn <= 1'b1;
              st  <= T_GAP;
            end else begin
              sh   <= {sh[FRAME_W-2:0], 1'b0};
              bitn <= bitn + BW'(1);
              st   <= T_LO;
            end
          end else cnt <= cnt + CW'(1);
        end
        default: begin
          if (cnt == HALF_END) begin
            cnt <= '0;
            st  <= T_IDLE;
          end else cnt <= cnt + CW'(1);
        end
      endcase
    end
  end

  assign in_rdy = (st == T_IDLE);
  assign mosi   = sh[FRAME_W-1];

  // R3
  mosi_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn && $past(!csn) && !$fell(sck)) |-> $stable(mosi));

  // R3
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csn) |-> !sck);

endmodule

// File: rtl/panel_seq_top.sv
module panel_seq_top
  import panel_seq_pkg::*;
#(
  parameter int CLK_KHZ  = 125000,
  parameter int RST_US   = 60,
  parameter int BL_MS    = 120,
  parameter int SCK_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prep_req,
  input  logic unprep_req,
  input  logic wake_req,
  input  logic sleep_req,
  input  logic backlight_present,
  input  logic supply_ack,
  output logic supply_req,
  output logic panel_rst,
  output logic spi_csn,
  output logic spi_sck,
  output logic spi_mosi,
  output logic busy,
  output logic prep_done,
  output logic prep_err,
  output logic pic_ready
);

  localparam int RST_CYC = (CLK_KHZ * RST_US + 999) / 1000;
  localparam int BL_CYC  = CLK_KHZ * BL_MS;
  localparam int TMAX    = (BL_CYC > RST_CYC) ? BL_CYC : RST_CYC;
  localparam int TW      = $clog2(TMAX + 1);
  localparam int IW      = $clog2(INIT_LEN);
  localparam logic [IW-1:0] LAST_IDX = IW'(INIT_LEN - 1);

  seq_st_e        st;
  seq_op_e        op;
  logic [IW-1:0]  idx;
  reg_wr_t        one_word;
  reg_wr_t        rom_word;
  logic           supply_q, rst_q, done_q, err_q, pic_q;

  logic           tmr_start, tmr_done;
  logic [TW-1:0]  tmr_load;
  logic           tx_vld, tx_rdy, tx_fire;
  logic [FRAME_W-1:0] tx_word;

  panel_init_rom #(.IW(IW)) u_rom (
    .idx (idx),
    .wr  (rom_word)
  );

  panel_delay #(.W(TW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .load    (tmr_load),
    .expired (tmr_done)
  );

  panel_spi_tx #(.FRAME_W(FRAME_W), .HALF(SCK_HALF)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (tx_vld),
    .in_data (tx_word),
    .in_rdy  (tx_rdy),
    .csn     (spi_csn),
    .sck     (spi_sck),
    .mosi    (spi_mosi)
  );

  always_comb begin
    tmr_start = (st == ST_PWR && supply_ack) ||
                (st == ST_RSTHOLD && tmr_done) ||
                (st == ST_DRAIN && op == OP_WAKE && tx_rdy && backlight_present);
    tmr_load  = (st == ST_DRAIN) ? TW'(BL_CYC) : TW'(RST_CYC);
    tx_vld    = (st == ST_INIT && supply_ack) || (st == ST_ONE);
    tx_word   = (st == ST_ONE) ? one_word : rom_word;
    tx_fire   = tx_vld && tx_rdy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      op       <= OP_PREP;
      idx      <= '0;
      one_word <= '0;
      supply_q <= 1'b0;
      rst_q    <= 1'b1;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      pic_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      pic_q  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (unprep_req) begin
            rst_q <= 1'b1;
            st    <= ST_UNPREP;
          end else if (sleep_req) begin
            one_word <= '{STBY_ADDR, 8'h00};
            op       <= OP_SLEEP;
            st       <= ST_ONE;
          end else if (wake_req) begin
            one_word <= '{STBY_ADDR, 8'h01};
            op       <= OP_WAKE;
            st       <= ST_ONE;
          end else if (prep_req) begin
            supply_q <= 1'b1;
            op       <= OP_PREP;
            st       <= ST_PWR;
          end
        end
        ST_UNPREP: begin
          supply_q <= 1'b0;
          st       <= ST_IDLE;
        end
        ST_PWR: if (supply_ack) begin
          rst_q <= 1'b1;
          st    <= ST_RSTHOLD;
        end
        ST_RSTHOLD: if (tmr_done) begin
          rst_q <= 1'b0;
          st    <= ST_SETTLE;
        end
        ST_SETTLE: if (tmr_done) begin
          idx <= '0;
          st  <= ST_INIT;
        end
        ST_INIT: begin
          if (tx_rdy && !supply_ack) begin
            supply_q <= 1'b0;
            err_q    <= 1'b1;
            st       <= ST_IDLE;
          end else if (tx_fire) begin
            if (idx == LAST_IDX) st <= ST_DRAIN;
            else                 idx <= idx + IW'(1);
          end
        end
        ST_ONE: if (tx_fire) st <= ST_DRAIN;
        ST_DRAIN: if (tx_rdy) begin
          case (op)
            OP_PREP: begin
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end
            OP_WAKE: begin
              if (backlight_present) st <= ST_BLWAIT;
              else begin
                pic_q <= 1'b1;
                st    <= ST_IDLE;
              end
            end
            default: st <= ST_IDLE;
          endcase
        end
        ST_BLWAIT: if (tmr_done) begin
          pic_q <= 1'b1;
          st    <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign supply_req = supply_q;
  assign panel_rst  = rst_q;
  assign busy       = (st != ST_IDLE);
  assign prep_done  = done_q;
  assign prep_err   = err_q;
  assign pic_ready  = pic_q;

  // R7
  rst_before_supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_req) |-> (panel_rst || prep_err));

  // R2
  rst_release_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(panel_rst) |-> supply_req);

  // R4
  addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire |-> (tx_word[15:8] <= MAX_ADDR));

  // R4
  done_when_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prep_done |-> (supply_req && !panel_rst && spi_csn));

  // R8
  err_supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prep_err |-> (!supply_req && !prep_done));

endmodule

// File: tb/tb_panel_seq_top.sv
module tb_panel_seq_top;

  localparam int CLK_KHZ = 400;
  localparam int MIN_RST = 50 * CLK_KHZ / 1000;
  localparam int MIN_BL  = 120 * CLK_KHZ;
  localparam logic [15:0] REF_INIT [35] = '{
    16'h051E, 16'h055C, 16'h0214, 16'h0340, 16'h0407, 16'h0612, 16'h07D2,
    16'h0C06, 16'h0D40, 16'h0E40, 16'h0F40, 16'h1040, 16'h1140, 16'h2F40,
    16'h5A02, 16'h3007, 16'h3157, 16'h3253, 16'h3377, 16'h34B8, 16'h35BD,
    16'h36B8, 16'h37E7, 16'h3804, 16'h39FF, 16'h400B, 16'h41B8, 16'h42AB,
    16'h43B9, 16'h446A, 16'h4556, 16'h4661, 16'h4708, 16'h480F, 16'h490F};

  logic clk = 1'b0, rst_n = 1'b0;
  logic prep_req = 0, unprep_req = 0, wake_req = 0, sleep_req = 0;
  logic backlight_present = 0, supply_ack = 0;
  logic supply_req, panel_rst, spi_csn, spi_sck, spi_mosi;
  logic busy, prep_done, prep_err, pic_ready;

  panel_seq_top #(.CLK_KHZ(CLK_KHZ), .RST_US(60), .BL_MS(120), .SCK_HALF(2)) dut (
    .clk(clk), .rst_n(rst_n), .prep_req(prep_req), .unprep_req(unprep_req),
    .wake_req(wake_req), .sleep_req(sleep_req),
    .backlight_present(backlight_present), .supply_ack(supply_ack),
    .supply_req(supply_req), .panel_rst(panel_rst), .spi_csn(spi_csn),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .busy(busy),
    .prep_done(prep_done), .prep_err(prep_err), .pic_ready(pic_ready));

  always #4 clk = ~clk;

  int vectors = 0, fails = 0;
  bit finished = 0;
  bit ack_kill = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  int cyc = 0, frames = 0, nbits = 0;
  logic [15:0] fbits = '0;
  logic prev_csn = 1, prev_sck = 0, prev_ack = 0, prev_rst = 1, prev_sup = 0;
  int ack_rise_cyc = 0, rst_fall_cyc = 0, rst_rise_cyc = 0, sup_fall_cyc = 0;
  int first_cs_cyc = -1, frame_end_cyc = 0, pic_cyc = 0;
  int done_cnt = 0, err_cnt = 0, pic_cnt = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // supply model: acknowledge follows the request one cycle later
  always @(negedge clk) supply_ack <= ack_kill ? 1'b0 : supply_req;

  // reference model and per-clock comparison
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      vectors++;
      if (!spi_csn && exp_q.size() == 0) begin
        fails++;
        $display("FAIL R9 unexpected frame activity: actual csn=0 expected csn=1");
      end
      vectors++;
      if (spi_csn && spi_sck) begin
        fails++;
        $display("FAIL R3 sck outside frame: actual sck=1 expected sck=0");
      end
      if (!spi_csn && prev_csn) begin
        nbits = 0;
        if (first_cs_cyc < 0) first_cs_cyc = cyc;
      end
      if (!spi_csn && spi_sck && !prev_sck) begin
        fbits = {fbits[14:0], spi_mosi};
        nbits++;
      end
      if (spi_csn && !prev_csn) begin
        frames++;
        frame_end_cyc = cyc;
        chk(nbits == 16, "R3", "bits per frame", nbits, 16);
        if (exp_q.size() > 0) begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(fbits == e, t, "frame word", int'(fbits), int'(e));
        end
      end
      if (supply_ack && !prev_ack) ack_rise_cyc = cyc;
      if (!panel_rst && prev_rst) rst_fall_cyc = cyc;
      if (panel_rst && !prev_rst) rst_rise_cyc = cyc;
      if (!supply_req && prev_sup) sup_fall_cyc = cyc;
      if (prep_done) done_cnt++;
      if (prep_err) err_cnt++;
      if (pic_ready) begin
        pic_cnt++;
        pic_cyc = cyc;
      end
      prev_csn = spi_csn; prev_sck = spi_sck; prev_ack = supply_ack;
      prev_rst = panel_rst; prev_sup = supply_req;
    end
  end

  task automatic pulse(input int which);
    @(negedge clk);
    prep_req   = (which == 0);
    unprep_req = (which == 1);
    wake_req   = (which == 2);
    sleep_req  = (which == 3);
    @(negedge clk);
    prep_req = 0; unprep_req = 0; wake_req = 0; sleep_req = 0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic push_init(string t);
    for (int i = 0; i < 35; i++) begin
      exp_q.push_back(REF_INIT[i]);
      tag_q.push_back(t);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    int f0, d0, e0, p0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(panel_rst == 1, "R1", "panel_rst", panel_rst, 1);
    chk(supply_req == 0, "R1", "supply_req", supply_req, 0);
    chk(spi_csn == 1 && spi_sck == 0, "R1", "csn/sck idle", {spi_csn, spi_sck}, 2);
    chk(busy == 0, "R1", "busy", busy, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R4 prepare; R9 wake raised mid-stream must be ignored
    f0 = frames; d0 = done_cnt;
    push_init("R4");
    first_cs_cyc = -1;
    pulse(0);
    repeat (2) @(negedge clk);
    chk(supply_req == 1, "R2", "supply_req raised", supply_req, 1);
    while (frames < f0 + 3) @(negedge clk);
    pulse(2);
    wait_idle();
    chk(rst_fall_cyc - ack_rise_cyc >= MIN_RST, "R2", "reset hold cycles",
        rst_fall_cyc - ack_rise_cyc, MIN_RST);
    chk(first_cs_cyc - rst_fall_cyc >= MIN_RST, "R2", "settle cycles",
        first_cs_cyc - rst_fall_cyc, MIN_RST);
    chk(frames - f0 == 35, "R4", "init frame count", frames - f0, 35);
    chk(done_cnt - d0 == 1, "R4", "done pulses", done_cnt - d0, 1);
    chk(frames - f0 == 35 && exp_q.size() == 0, "R9", "no extra frame from busy wake",
        exp_q.size(), 0);

    // R10 wake and sleep in the same cycle: sleep only
    f0 = frames;
    exp_q.push_back(16'h2B00); tag_q.push_back("R10");
    @(negedge clk);
    wake_req = 1; sleep_req = 1;
    @(negedge clk);
    wake_req = 0; sleep_req = 0;
    wait_idle();
    chk(frames - f0 == 1, "R10", "frames for wake+sleep", frames - f0, 1);

    // R5 wake without backlight
    p0 = pic_cnt;
    exp_q.push_back(16'h2B01); tag_q.push_back("R5");
    pulse(2);
    wait_idle();
    chk(pic_cnt - p0 == 1, "R5", "pic_ready pulses", pic_cnt - p0, 1);
    chk(pic_cyc - frame_end_cyc <= 8, "R5", "pic_ready delay no backlight",
        pic_cyc - frame_end_cyc, 8);

    // R6 sleep
    f0 = frames;
    exp_q.push_back(16'h2B00); tag_q.push_back("R6");
    pulse(3);
    wait_idle();
    chk(frames - f0 == 1, "R6", "sleep frame count", frames - f0, 1);

    // R5 wake with backlight
    backlight_present = 1;
    p0 = pic_cnt;
    exp_q.push_back(16'h2B01); tag_q.push_back("R5");
    pulse(2);
    while (pic_cnt == p0) @(negedge clk);
    chk(pic_cyc - frame_end_cyc >= MIN_BL, "R5", "backlight wait cycles",
        pic_cyc - frame_end_cyc, MIN_BL);
    wait_idle();
    backlight_present = 0;

    // R7 unprepare ordering
    pulse(1);
    wait_idle();
    chk(panel_rst == 1 && supply_req == 0, "R7", "unprepared state",
        {panel_rst, supply_req}, 2);
    chk(sup_fall_cyc - rst_rise_cyc == 1, "R7", "reset-to-supply-drop cycles",
        sup_fall_cyc - rst_rise_cyc, 1);

    // R10 unprepare and prepare in the same cycle: unprepare wins
    f0 = frames;
    @(negedge clk);
    unprep_req = 1; prep_req = 1;
    @(negedge clk);
    unprep_req = 0; prep_req = 0;
    repeat (60) @(negedge clk);
    chk(supply_req == 0, "R10", "supply after unprep+prep", supply_req, 0);
    chk(frames == f0, "R10", "frames after unprep+prep", frames - f0, 0);

    // R8 supply lost during init
    f0 = frames; d0 = done_cnt; e0 = err_cnt;
    push_init("R8");
    pulse(0);
    while (frames < f0 + 5) @(negedge clk);
    ack_kill = 1;
    wait_idle();
    repeat (20) @(negedge clk);
    chk(err_cnt - e0 == 1, "R8", "error pulses", err_cnt - e0, 1);
    chk(done_cnt == d0, "R8", "done pulses on abort", done_cnt - d0, 0);
    chk(supply_req == 0, "R8", "supply_req after abort", supply_req, 0);
    chk(frames - f0 < 35, "R8", "frames before abort", frames - f0, 6);
    exp_q.delete(); tag_q.delete();
    ack_kill = 0;
    repeat (4) @(negedge clk);

    // R4 prepare again after an abort
    f0 = frames; d0 = done_cnt;
    push_init("R4");
    pulse(0);
    wait_idle();
    chk(frames - f0 == 35, "R4", "re-prepare frame count", frames - f0, 35);
    chk(done_cnt - d0 == 1 && panel_rst == 0, "R4", "re-prepare done",
        done_cnt - d0, 1);

    summary();
  end

endmodule